// File: doc/BRIEF.md
# Battery Charge Sequence Controller

This block steps a battery charger through one charge cycle. Its inputs are comparator results that have already been turned into logic levels: adapter present, shutdown, cell below the low-voltage threshold, cell below the recharge threshold, charge current at one tenth of full scale, input current limit active, and temperature out of range. A strap input can also disable termination. The block drives the charge enable and three active-low indicators: charge status, fault and a latched C/10 flag.

The total charge time is a programmable count of prescaled ticks. A slow strobe input drives the count, and a prescaler divides that strobe by `PRESCALE`. A low cell that lasts for one quarter of the total time ends the cycle with a fault. When the C/10 condition is first seen, the remaining time is set to one quarter of the total. A temperature excursion pauses the cycle and freezes the timer. After a time-out, the block starts a new cycle on its own when the cell falls below the recharge level.

Top module: `chg_seq_ctrl`

## Requirements
- R1: In the idle state, when `adapter_ok` is 1 and `shdn` is 0, the block enters charging on the next clock. Charging means `chg_en`=1 and `stat_n`=0.
- R2: While `rst_n` is low the outputs are `chg_en`=0, `stat_n`=1, `fault_n`=1 and `c10_flag_n`=1.
- R3: With `term_defeat_n`=1, charging ends after `total_time`*`PRESCALE` tick strobes spent charging. At that point `chg_en`=0 and `stat_n`=1 (status released).
- R4: If `cell_low` stays at 1 for (`total_time`>>2)*`PRESCALE` strobes while charging, the block enters a fault state with `fault_n`=0 and `chg_en`=0. This state ignores `below_recharge` and is left only through shutdown or adapter removal.
- R5: Each cycle in which `cell_low` is 0 clears the low-cell persistence count.
- R6: While `therm_bad`=1 during charging, `chg_en`=0 and `fault_n`=0, and the timer and prescaler hold their values. When `therm_bad` returns to 0, charging resumes with the charge time left unchanged.
- R7: The first `c10_hit` of a cycle latches `c10_flag_n` low and leaves exactly (`total_time`>>2)*`PRESCALE` strobes before time-out. Further `c10_hit` pulses in the same cycle do not change the timer.
- R8: A `c10_hit` that arrives while `ilim_active`=1 does not latch the flag and does not change the timer.
- R9: While `term_defeat_n`=0, time-out does not end charging. Raising `term_defeat_n` after the time has run out ends charging on the next clock.
- R10: After a time-out, `below_recharge`=1 starts a new cycle on the next clock, and that cycle has the full charge time.
- R11: A one-cycle `shdn` pulse resets the timer and restarts the cycle. Removing and then reapplying `adapter_ok` has the same effect. While `shdn` is 1, `chg_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_in | input | 1 | One-cycle time-base strobe |
| adapter_ok | input | 1 | Input supply present |
| shdn | input | 1 | Shutdown; a high level inhibits charging and resets the timer |
| cell_low | input | 1 | Cell below the low-voltage threshold |
| below_recharge | input | 1 | Cell below the automatic recharge threshold |
| c10_hit | input | 1 | Charge current has fallen to one tenth of full scale |
| ilim_active | input | 1 | Input current limit is reducing charge current |
| therm_bad | input | 1 | Thermistor reading out of range |
| term_defeat_n | input | 1 | Low level disables time-out termination |
| total_time | input | TW | Total charge time in prescaled ticks (at least 4) |
| chg_en | output | 1 | Charger enable |
| stat_n | output | 1 | Charge status; 0 = charging, 1 = released |
| fault_n | output | 1 | Fault indicator, active low |
| c10_flag_n | output | 1 | Latched C/10 indicator, active low |

## Verification
The assertions assume that `total_time` is at least 4 and stays constant within a cycle. They also assume that `c10_hit` and a prescaled tick never arrive in the same clock. The stimulus changes `total_time` only while the block is idle or finished, and it then restarts with a shutdown pulse. It sends strobes and `c10_hit` pulses in separate cycles. Every C/10 pulse is placed on a prescaler boundary, so the remaining-strobe counts are exact multiples of `PRESCALE`.

// File: rtl/chg_seq_pkg.sv
package chg_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_CHARGE = 3'd1,
    ST_HOLD   = 3'd2,
    ST_DONE   = 3'd3,
    ST_FAULT  = 3'd4
  } chg_state_e;
endpackage

// File: rtl/chg_prescaler.sv
module chg_prescaler #(
  parameter int PRESCALE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic tick_in,
  output logic tick_p
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  generate
    if (PRESCALE > 1) begin : g_div
      logic [PW-1:0] cnt;
      logic          wrap;
      assign wrap   = (cnt == PW'(PRESCALE - 1));
      assign tick_p = en && tick_in && wrap;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (clr)            cnt <= '0;
        else if (en && tick_in)  cnt <= wrap ? '0 : cnt + 1'b1;
      end
    end else begin : g_pass
      logic unused_ok;
      assign unused_ok = clk ^ rst_n ^ clr;
      assign tick_p    = en && tick_in;
    end
  endgenerate
endmodule

// File: rtl/chg_charge_timer.sv
module chg_charge_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          tick_p,
  input  logic [TW-1:0] total,
  output logic [TW-1:0] elapsed,
  output logic          expired
);
  assign expired = (elapsed >= total);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       elapsed <= '0;
    else if (clr)                     elapsed <= '0;
    else if (load)                    elapsed <= load_val;
    else if (tick_p && !expired)      elapsed <= elapsed + 1'b1;
  end
endmodule

// File: rtl/chg_lowcell_watch.sv
module chg_lowcell_watch #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          cell_low,
  input  logic          tick_p,
  input  logic [TW-1:0] limit,
  output logic          expire
);
  logic [TW-1:0] persist;

  assign expire = cell_low && (persist >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          persist <= '0;
    else if (clr || !cell_low)           persist <= '0;
    else if (tick_p && persist < limit)  persist <= persist + 1'b1;
  end
endmodule

// File: rtl/chg_seq_ctrl.sv
module chg_seq_ctrl
  import chg_seq_pkg::*;
#(
  parameter int TW       = 16,
  parameter int PRESCALE = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_in,
  input  logic          adapter_ok,
  input  logic          shdn,
  input  logic          cell_low,
  input  logic          below_recharge,
  input  logic          c10_hit,
  input  logic          ilim_active,
  input  logic          therm_bad,
  input  logic          term_defeat_n,
  input  logic [TW-1:0] total_time,
  output logic          chg_en,
  output logic          stat_n,
  output logic          fault_n,
  output logic          c10_flag_n
);
  function automatic logic [TW-1:0] quarter_of(input logic [TW-1:0] t);
    return t >> 2;
  endfunction

  function automatic logic [TW-1:0] rewind_point(input logic [TW-1:0] t);
    return t - quarter_of(t);
  endfunction

  chg_state_e    st, nxt;
  logic          go_idle, clr, run, tick_p;
  logic          timeout, low_expire, c10_evt, c10_latched, restart_evt;
  logic [TW-1:0] elapsed;

  assign go_idle     = shdn || !adapter_ok;
  assign run         = (st == ST_CHARGE) && !go_idle;
  assign restart_evt = (st == ST_DONE) && below_recharge;
  assign clr         = go_idle || (st == ST_IDLE) || restart_evt;
  assign c10_evt     = run && c10_hit && !ilim_active && !c10_latched;

  chg_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .en      (run),
    .tick_in (tick_in),
    .tick_p  (tick_p)
  );

  chg_charge_timer #(.TW(TW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .load     (c10_evt),
    .load_val (rewind_point(total_time)),
    .tick_p   (tick_p),
    .total    (total_time),
    .elapsed  (elapsed),
    .expired  (timeout)
  );

  chg_lowcell_watch #(.TW(TW)) u_low (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .cell_low (cell_low),
    .tick_p   (tick_p),
    .limit    (quarter_of(total_time)),
    .expire   (low_expire)
  );

  always_comb begin
    nxt = st;
    if (go_idle) begin
      nxt = ST_IDLE;
    end else begin
      case (st)
        ST_IDLE:   nxt = ST_CHARGE;
        ST_CHARGE: begin
          if (low_expire)                     nxt = ST_FAULT;
          else if (therm_bad)                 nxt = ST_HOLD;
          else if (timeout && term_defeat_n)  nxt = ST_DONE;
        end
        ST_HOLD:   if (!therm_bad)      nxt = ST_CHARGE;
        ST_DONE:   if (below_recharge)  nxt = ST_CHARGE;
        ST_FAULT:  nxt = ST_FAULT;
        default:   nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        c10_latched <= 1'b0;
    else if (clr)      c10_latched <= 1'b0;
    else if (c10_evt)  c10_latched <= 1'b1;
  end

  assign chg_en     = (st == ST_CHARGE);
  assign stat_n     = !((st == ST_CHARGE) || (st == ST_HOLD));
  assign fault_n    = !((st == ST_FAULT) || (st == ST_HOLD));
  assign c10_flag_n = !c10_latched;
endmodule

module chg_seq_ctrl_chk
  import chg_seq_pkg::*;
#(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          adapter_ok,
  input logic          shdn,
  input logic          therm_bad,
  input logic          ilim_active,
  input logic          term_defeat_n,
  input logic          chg_en,
  input logic          stat_n,
  input logic          fault_n,
  input logic          c10_flag_n,
  input chg_state_e    st,
  input logic          timeout,
  input logic          low_expire,
  input logic [TW-1:0] elapsed
);
  logic live;
  assign live = adapter_ok && !shdn;

  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) && live |=> chg_en && !stat_n);

  p_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CHARGE) && live && timeout && term_defeat_n && !low_expire && !therm_bad
      |=> !chg_en && stat_n && fault_n);

  p_lowcell_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CHARGE) && live && low_expire |=> !fault_n && !chg_en);

  p_fault_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FAULT) && live |=> !fault_n && !chg_en);

  p_thermal_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CHARGE) && live && therm_bad && !low_expire |=> !chg_en && !fault_n);

  p_timer_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HOLD) && live |=> $stable(elapsed));

  p_ilim_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    c10_flag_n && ilim_active |=> c10_flag_n);

  p_defeat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CHARGE) && live && !term_defeat_n && !therm_bad && !low_expire |=> chg_en);

  p_shdn_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    shdn |=> !chg_en);

  p_fault_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_n |-> !chg_en);
endmodule

bind chg_seq_ctrl chg_seq_ctrl_chk #(.TW(TW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .adapter_ok    (adapter_ok),
  .shdn          (shdn),
  .therm_bad     (therm_bad),
  .ilim_active   (ilim_active),
  .term_defeat_n (term_defeat_n),
  .chg_en        (chg_en),
  .stat_n        (stat_n),
  .fault_n       (fault_n),
  .c10_flag_n    (c10_flag_n),
  .st            (st),
  .timeout       (timeout),
  .low_expire    (low_expire),
  .elapsed       (elapsed)
);

// File: tb/sim_chg_seq_ctrl.sv
`timescale 1ns/1ps
module sim_chg_seq_ctrl;
  localparam int TW = 6;
  localparam int P  = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_in = 1'b0, adapter_ok = 1'b0, shdn = 1'b0, cell_low = 1'b0;
  logic          below_recharge = 1'b0, c10_hit = 1'b0, ilim_active = 1'b0;
  logic          therm_bad = 1'b0, term_defeat_n = 1'b1;
  logic [TW-1:0] total_time = 6'd8;
  logic          chg_en, stat_n, fault_n, c10_flag_n;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  chg_seq_ctrl #(.TW(TW), .PRESCALE(P)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .adapter_ok(adapter_ok),
    .shdn(shdn), .cell_low(cell_low), .below_recharge(below_recharge),
    .c10_hit(c10_hit), .ilim_active(ilim_active), .therm_bad(therm_bad),
    .term_defeat_n(term_defeat_n), .total_time(total_time),
    .chg_en(chg_en), .stat_n(stat_n), .fault_n(fault_n), .c10_flag_n(c10_flag_n)
  );

  function automatic int full_strobes(input int t);
    return t * P;
  endfunction

  function automatic int quarter_strobes(input int t);
    return (t / 4) * P;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe();
    tick_in = 1'b1;
    @(negedge clk);
    tick_in = 1'b0;
    @(negedge clk);
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) strobe();
  endtask

  task automatic restart();
    shdn = 1'b1;
    @(negedge clk);
    shdn = 1'b0;
    @(negedge clk);
  endtask

  task automatic c10_pulse();
    c10_hit = 1'b1;
    @(negedge clk);
    c10_hit = 1'b0;
  endtask

  task automatic until_off(output int n);
    n = 0;
    while (chg_en && n < 4000) begin
      strobe();
      n++;
    end
  endtask

  task automatic until_fault(output int n);
    n = 0;
    while (fault_n && n < 4000) begin
      strobe();
      n++;
    end
  endtask

  initial begin : wdog
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int n;
    int ks[4];
    ks = '{0, 4, 10, 20};
    cyc(3);
    chk("R2 chg_en", chg_en, 0);
    chk("R2 stat_n", stat_n, 1);
    chk("R2 fault_n", fault_n, 1);
    chk("R2 c10_flag_n", c10_flag_n, 1);
    rst_n = 1'b1;
    cyc(2);
    chk("R1 idle without adapter", chg_en, 0);
    adapter_ok = 1'b1;
    cyc(1);
    chk("R1 chg_en", chg_en, 1);
    chk("R1 stat_n", stat_n, 0);

    // R3: time-out sweep
    for (int t = 4; t < 16; t++) begin
      total_time = TW'(t);
      restart();
      until_off(n);
      chk("R3 strobes to time-out", n, full_strobes(t));
      chk("R3 status released", stat_n, 1);
    end

    // R4: low-cell persistence sweep
    cell_low = 1'b1;
    for (int t = 4; t < 16; t++) begin
      total_time = TW'(t);
      restart();
      until_fault(n);
      chk("R4 strobes to fault", n, quarter_strobes(t));
      chk("R4 chg_en off", chg_en, 0);
    end
    below_recharge = 1'b1;
    strobes(4);
    chk("R4 fault persists", fault_n, 0);
    below_recharge = 1'b0;
    cell_low = 1'b0;
    restart();
    chk("R4 left by shutdown fault_n", fault_n, 1);
    chk("R4 left by shutdown chg_en", chg_en, 1);

    // R5: persistence count clears
    total_time = 6'd12;
    cell_low = 1'b1;
    restart();
    strobes(4);
    cell_low = 1'b0;
    cyc(1);
    cell_low = 1'b1;
    until_fault(n);
    chk("R5 count restarted", n, quarter_strobes(12));
    cell_low = 1'b0;

    // R6: thermal hold
    total_time = 6'd10;
    restart();
    strobes(6);
    therm_bad = 1'b1;
    cyc(1);
    chk("R6 hold chg_en", chg_en, 0);
    chk("R6 hold fault_n", fault_n, 0);
    strobes(10);
    chk("R6 still held", chg_en, 0);
    therm_bad = 1'b0;
    cyc(1);
    chk("R6 resume chg_en", chg_en, 1);
    chk("R6 resume fault_n", fault_n, 1);
    until_off(n);
    chk("R6 time kept", n, full_strobes(10) - 6);

    // R7: C/10 rewind
    total_time = 6'd12;
    for (int i = 0; i < 4; i++) begin
      restart();
      strobes(ks[i]);
      c10_pulse();
      chk("R7 flag latched", c10_flag_n, 0);
      strobes(2);
      c10_pulse();
      until_off(n);
      chk("R7 remaining strobes", n, quarter_strobes(12) - 2);
    end

    // R8: current limit blocks latch
    restart();
    chk("R8 flag cleared on restart", c10_flag_n, 1);
    strobes(4);
    ilim_active = 1'b1;
    c10_pulse();
    chk("R8 flag not latched", c10_flag_n, 1);
    ilim_active = 1'b0;
    until_off(n);
    chk("R8 timer untouched", n, full_strobes(12) - 4);

    // R9: termination defeat
    total_time = 6'd6;
    term_defeat_n = 1'b0;
    restart();
    strobes(full_strobes(6) + 6);
    chk("R9 still charging", chg_en, 1);
    chk("R9 status driven", stat_n, 0);
    term_defeat_n = 1'b1;
    cyc(1);
    chk("R9 ends on release", chg_en, 0);

    // R10: automatic recharge
    cyc(3);
    chk("R10 waits in done", chg_en, 0);
    below_recharge = 1'b1;
    cyc(1);
    below_recharge = 1'b0;
    chk("R10 restarted", chg_en, 1);
    until_off(n);
    chk("R10 full time", n, full_strobes(6));

    // R11: shutdown pulse and adapter cycling
    total_time = 6'd10;
    restart();
    strobes(8);
    restart();
    until_off(n);
    chk("R11 shdn pulse resets timer", n, full_strobes(10));
    shdn = 1'b1;
    cyc(3);
    chk("R11 shdn holds off", chg_en, 0);
    shdn = 1'b0;
    cyc(1);
    strobes(8);
    adapter_ok = 1'b0;
    cyc(2);
    chk("R11 adapter removed", chg_en, 0);
    adapter_ok = 1'b1;
    cyc(1);
    chk("R11 adapter back", chg_en, 1);
    until_off(n);
    chk("R11 adapter resets timer", n, full_strobes(10));

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule